// File: doc/BRIEF.md
# ADC Channel Interrupt Flag Logic

This block keeps the interrupt configuration and the interrupt flag for one channel of an analog-to-digital converter. Each time the converter pulses its conversion-done strobe, the block looks at the new result. Depending on the programmed mode, it raises the channel flag on every completion, only when the result is strictly under a compare threshold, or only when it is strictly over it. One mode code is held back and never raises the flag.

While the flag is up and the programmed priority level is nonzero, the block drives an interrupt request together with that level. The flag drops when the interrupt controller acknowledges it, or when software writes a one to the flag bit. A set event in the same cycle as a clear wins, so no conversion is lost. Software reaches both registers through a small select/write/read port. The read data is combinational on the select.

Top module: `adc_chan_irq`

## Requirements
- R1: After synchronous reset, both registers read as zero and `irq_req` is low.
- R2: A write with `reg_sel`=0 stores write-data bits 3:2 as the mode and bits 1:0 as the level. The update is visible on the next cycle. Read-back bits 7:4 of the control register are always zero.
- R3: In mode 00, every `conv_done` pulse sets the flag one cycle later.
- R4: In mode 01, a `conv_done` sets the flag only when `conv_result` < `threshold` (unsigned, strict).
- R5: In mode 11, a `conv_done` sets the flag only when `conv_result` > `threshold` (unsigned, strict).
- R6: In mode 10, no conversion sets the flag.
- R7: `irq_req` is high exactly while the flag is set and the level is nonzero. `irq_level` always shows the stored level.
- R8: A pulse on `irq_ack` clears the flag on the next cycle.
- R9: A write with `reg_sel`=1 and write-data bit 0 = 1 clears the flag. When bit 0 = 0, the write leaves the flag unchanged.
- R10: When a set event and a clear (acknowledge or software write) fall in the same cycle, the flag ends up set.
- R11: With `reg_sel`=1, read data carries the flag in bit 0 and zeros in bits 7:1. A write to the flag register leaves the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register select: 0 control, 1 flag |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rd_data | output | 8 | Read data of the selected register |
| conv_done | input | 1 | One-cycle conversion-complete strobe |
| conv_result | input | 12 | Conversion result, valid with `conv_done` |
| threshold | input | 12 | Compare threshold |
| irq_ack | input | 1 | Interrupt serviced pulse |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 2 | Priority level of the request |

## Verification
A wrong flag state shows up on `irq_req` and on flag read-back in the cycle after the conversion or clear that caused it. The only exception is a level of zero, where only the read port reveals it. A corrupted mode or level is seen at once on control read-back and on `irq_level`. A wrong mode also shows up at the next conversion whose result falls on the other side of the threshold. For that reason the stimulus places results just below, exactly at, and just above the threshold.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;

    localparam int REG_W      = 8;
    localparam int RESULT_W   = 12;
    localparam int FIELD_W    = 2;
    localparam int CTRL_USED  = 2 * FIELD_W;

    typedef enum logic [FIELD_W-1:0] {
        MODE_DONE  = 2'b00,
        MODE_BELOW = 2'b01,
        MODE_RSVD  = 2'b10,
        MODE_ABOVE = 2'b11
    } irq_mode_e;

    typedef struct packed {
        irq_mode_e          mode;
        logic [FIELD_W-1:0] level;
    } irq_ctrl_t;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_FLAG = 1'b1
    } reg_sel_e;

    // Decide whether a finished conversion qualifies, given compare results.
    function automatic logic mode_hit(irq_mode_e m, logic lt, logic gt);
        case (m)
            MODE_DONE:  return 1'b1;
            MODE_BELOW: return lt;
            MODE_ABOVE: return gt;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/adc_irq_ctrl_reg.sv
module adc_irq_ctrl_reg
    import adc_irq_pkg::*;
#(
    parameter int USED_W = CTRL_USED
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [USED_W-1:0] wdata,
    output irq_ctrl_t         ctrl_q
);
    localparam int MODE_LSB = USED_W - FIELD_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{mode: MODE_DONE, level: '0};
        end else if (wr_en) begin
            ctrl_q.mode  <= irq_mode_e'(wdata[USED_W-1:MODE_LSB]);
            ctrl_q.level <= wdata[FIELD_W-1:0];
        end
    end
endmodule

// File: rtl/adc_irq_cmp.sv
module adc_irq_cmp
    import adc_irq_pkg::*;
#(
    parameter int RES_W = RESULT_W
) (
    input  logic             conv_done,
    input  logic [RES_W-1:0] result,
    input  logic [RES_W-1:0] thresh,
    input  irq_mode_e        mode,
    output logic             set_evt
);
    logic is_lt;
    logic is_gt;

    always_comb begin
        is_lt   = result < thresh;
        is_gt   = result > thresh;
        set_evt = conv_done && mode_hit(mode, is_lt, is_gt);
    end
endmodule

// File: rtl/adc_irq_flag.sv
module adc_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_evt,
    output logic flag_q
);
    logic flag_d;

    always_comb begin
        flag_d = flag_q;
        if (clr_evt) flag_d = 1'b0;
        if (set_evt) flag_d = 1'b1;   // a set in the same cycle overrides a clear
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= flag_d;
    end
endmodule

// File: rtl/adc_chan_irq.sv
module adc_chan_irq
    import adc_irq_pkg::*;
#(
    parameter int RES_W = RESULT_W,
    parameter int DW    = REG_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rd_data,
    input  logic               conv_done,
    input  logic [RES_W-1:0]   conv_result,
    input  logic [RES_W-1:0]   threshold,
    input  logic               irq_ack,
    output logic               irq_req,
    output logic [FIELD_W-1:0] irq_level
);
    irq_ctrl_t ctrl_q;
    logic      flag_q;
    logic      set_evt;
    logic      clr_evt;
    logic      wr_ctrl;
    logic      wr_flag;

    assign wr_ctrl = reg_wr && (reg_sel_e'(reg_sel) == SEL_CTRL);
    assign wr_flag = reg_wr && (reg_sel_e'(reg_sel) == SEL_FLAG);
    assign clr_evt = irq_ack || (wr_flag && reg_wdata[0]);

    adc_irq_ctrl_reg #(.USED_W(CTRL_USED)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_ctrl),
        .wdata  (reg_wdata[CTRL_USED-1:0]),
        .ctrl_q (ctrl_q)
    );

    adc_irq_cmp #(.RES_W(RES_W)) u_cmp (
        .conv_done (conv_done),
        .result    (conv_result),
        .thresh    (threshold),
        .mode      (ctrl_q.mode),
        .set_evt   (set_evt)
    );

    adc_irq_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_evt (set_evt),
        .clr_evt (clr_evt),
        .flag_q  (flag_q)
    );

    always_comb begin
        reg_rd_data = '0;
        if (reg_sel_e'(reg_sel) == SEL_CTRL) reg_rd_data[CTRL_USED-1:0] = ctrl_q;
        else                                 reg_rd_data[0] = flag_q;
    end

    assign irq_req   = flag_q && (ctrl_q.level != '0);
    assign irq_level = ctrl_q.level;
endmodule

// File: rtl/adc_chan_irq_chk.sv
module adc_chan_irq_chk
    import adc_irq_pkg::*;
#(
    parameter int RES_W = RESULT_W,
    parameter int DW    = REG_W
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_sel,
    input logic [DW-1:0]      reg_rd_data,
    input logic               conv_done,
    input logic [RES_W-1:0]   conv_result,
    input logic [RES_W-1:0]   threshold,
    input logic               irq_ack,
    input logic               irq_req,
    input logic [FIELD_W-1:0] irq_level,
    input irq_ctrl_t          ctrl_q,
    input logic               flag_q
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!flag_q && !irq_req));

    p_ctrl_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 1'b0) |-> (reg_rd_data[DW-1:CTRL_USED] == '0));

    p_done_sets_r3: assert property (@(posedge clk) disable iff (rst)
        (conv_done && ctrl_q.mode == MODE_DONE) |=> flag_q);

    p_below_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (conv_done && ctrl_q.mode == MODE_BELOW && conv_result < threshold) |=> flag_q);

    p_above_sets_r5: assert property (@(posedge clk) disable iff (rst)
        (conv_done && ctrl_q.mode == MODE_ABOVE && conv_result > threshold) |=> flag_q);

    p_rsvd_mode_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (!flag_q && ctrl_q.mode == MODE_RSVD) |=> !flag_q);

    p_req_has_level_r7: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_level != '0));

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !conv_done) |=> !flag_q);

    p_flag_rsvd_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 1'b1) |-> (reg_rd_data[DW-1:1] == '0));
endmodule

bind adc_chan_irq adc_chan_irq_chk #(.RES_W(RES_W), .DW(DW)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_sel     (reg_sel),
    .reg_rd_data (reg_rd_data),
    .conv_done   (conv_done),
    .conv_result (conv_result),
    .threshold   (threshold),
    .irq_ack     (irq_ack),
    .irq_req     (irq_req),
    .irq_level   (irq_level),
    .ctrl_q      (ctrl_q),
    .flag_q      (flag_q)
);

// File: tb/test_adc_chan_irq.sv
module test_adc_chan_irq;
    localparam int CLK_PERIOD = 10;
    localparam int RW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_sel = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rd_data;
    logic          conv_done = 1'b0;
    logic [RW-1:0] conv_result = '0;
    logic [RW-1:0] threshold = '0;
    logic          irq_ack = 1'b0;
    logic          irq_req;
    logic [1:0]    irq_level;

    int n_checks = 0;
    int n_fails  = 0;
    bit done_flag = 1'b0;

    logic [1:0] m_mode = 2'b00;
    logic [1:0] m_level = 2'b00;
    logic       m_flag = 1'b0;

    adc_chan_irq i_adc_chan_irq (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd_data(reg_rd_data),
        .conv_done(conv_done), .conv_result(conv_result), .threshold(threshold),
        .irq_ack(irq_ack), .irq_req(irq_req), .irq_level(irq_level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic exp_hit(logic [1:0] md, logic [RW-1:0] r, logic [RW-1:0] t);
        case (md)
            2'b00:   return 1'b1;
            2'b01:   return r < t;
            2'b11:   return r > t;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge: applies inputs for one rising edge, updates the model.
    task automatic cyc(logic sel, logic wr, logic [7:0] wd, logic dn,
                       logic [RW-1:0] res, logic [RW-1:0] thr, logic ack);
        logic hit;
        logic clr;
        reg_sel = sel; reg_wr = wr; reg_wdata = wd;
        conv_done = dn; conv_result = res; threshold = thr; irq_ack = ack;
        @(posedge clk);
        hit = dn && exp_hit(m_mode, res, thr);
        clr = ack || (wr && sel && wd[0]);
        if (wr && !sel) begin m_mode = wd[3:2]; m_level = wd[1:0]; end
        if (hit)      m_flag = 1'b1;
        else if (clr) m_flag = 1'b0;
        @(negedge clk);
        reg_wr = 1'b0; conv_done = 1'b0; irq_ack = 1'b0;
    endtask

    task automatic check_all(string tag);
        reg_sel = 1'b0; #1;
        chk({tag, " ctrl read"}, 32'(reg_rd_data), 32'({4'b0, m_mode, m_level}));
        reg_sel = 1'b1; #1;
        chk({tag, " flag read"}, 32'(reg_rd_data), 32'({7'b0, m_flag}));
        chk({tag, " irq_req R7"}, 32'(irq_req), 32'(m_flag && (m_level != 2'b00)));
        chk({tag, " irq_level R7"}, 32'(irq_level), 32'(m_level));
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done_flag) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all("R1 reset");

        // R2: all-ones write keeps only mode/level
        cyc(0, 1, 8'hFF, 0, 0, 0, 0);
        check_all("R2 write ff");
        chk("R2 reserved", 32'(reg_rd_data), 32'h0);  // flag sel: still zero

        // R3 with level 0: flag set but no request
        cyc(0, 1, 8'h00, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 12'd7, 12'd500, 0);
        check_all("R3 done mode");
        cyc(0, 1, 8'h02, 0, 0, 0, 0);
        check_all("R7 level 2");
        // R8 ack
        cyc(0, 0, 0, 0, 0, 0, 1);
        check_all("R8 ack");

        // R4 below
        cyc(0, 1, 8'h07, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 12'd100, 12'd100, 0);
        check_all("R4 equal no set");
        cyc(0, 0, 0, 1, 12'd101, 12'd100, 0);
        check_all("R4 above no set");
        cyc(0, 0, 0, 1, 12'd99, 12'd100, 0);
        check_all("R4 below set");

        // R9 software clear
        cyc(1, 1, 8'h00, 0, 0, 0, 0);
        check_all("R9 write zero kept");
        cyc(1, 1, 8'hFE, 0, 0, 0, 0);
        check_all("R9 write fe kept");
        cyc(1, 1, 8'h01, 0, 0, 0, 0);
        check_all("R9 write one clears");

        // R5 above
        cyc(0, 1, 8'h0D, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 12'd100, 12'd100, 0);
        check_all("R5 equal no set");
        cyc(0, 0, 0, 1, 12'd0, 12'd100, 0);
        check_all("R5 below no set");
        cyc(0, 0, 0, 1, 12'd4095, 12'd4094, 0);
        check_all("R5 above set");

        // R10 set beats ack and software clear
        cyc(0, 0, 0, 1, 12'd4095, 12'd0, 1);
        check_all("R10 set vs ack");
        cyc(1, 1, 8'h01, 1, 12'd5, 12'd1, 0);
        check_all("R10 set vs sw clear");

        // R11 flag write leaves control alone
        cyc(1, 1, 8'hFF, 0, 0, 0, 0);
        check_all("R11 flag write");

        // R6 reserved mode
        cyc(0, 1, 8'h09, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 12'd0, 12'd4095, 0);
        check_all("R6 low result");
        cyc(0, 0, 0, 1, 12'd4095, 12'd0, 0);
        check_all("R6 high result");
        cyc(0, 0, 0, 1, 12'd9, 12'd9, 0);
        check_all("R6 equal result");

        // Random mix, all requirements R2..R11 checked every cycle
        for (int i = 0; i < 3000; i++) begin
            logic [RW-1:0] thr;
            logic [RW-1:0] res;
            logic [3:0] pick;
            thr  = RW'($urandom_range(0, 4095));
            pick = 4'($urandom_range(0, 15));
            if (pick < 4)      res = thr;
            else if (pick < 7) res = thr - RW'(1);
            else if (pick < 10) res = thr + RW'(1);
            else               res = RW'($urandom_range(0, 4095));
            cyc(1'($urandom_range(0, 1)), ($urandom_range(0, 5) == 0),
                8'($urandom_range(0, 255)), ($urandom_range(0, 2) == 0),
                res, thr, ($urandom_range(0, 4) == 0));
            check_all("random R3 R4 R5 R6 R8 R9 R10");
        end

        done_flag = 1'b1;
        summary();
    end
endmodule